// File: doc/BRIEF.md
# Ethernet PHY Status LED Controller

This block drives a set of indicator LEDs from the status of an Ethernet PHY. The status inputs are link state, negotiated speed, power-down, energy-efficient mode, auto-negotiation, analog self-test, cable diagnostics, and three single-cycle activity strobes (transmit, receive, collision). Each LED has two 8-bit configuration words. Together they select a constant-on condition, a fast-blink condition, a slow-blink condition and an activity mask. Two shared words sit in front of the per-LED words; the first of them picks the fast and slow blink rates.

A free-running prescaler, derived from the `CLK_HZ` parameter, produces square waves at 2, 4, 8 and 16 Hz. Because every LED draws on this one prescaler, all LEDs set to the same rate blink in phase. A masked activity strobe holds its LED dark for about 50 ms, so that a single-cycle event stays visible to the eye. Configuration uses a plain write strobe with a word address. Read data is combinational.

Top module: `phy_led_ctrl`

## Requirements
- R1: The word address map is: 0 for the shared rate word, 1 for the shared auxiliary word, 2+2n for the high word of LED n and 3+2n for the low word of LED n. Any address outside this map reads 0 and ignores writes. After reset the words read 0x00C5, 0x0067, 0x0070, 0x0003, 0x0020, 0x0000, 0x0040, 0x0000, 0x0040 and 0x0020, in address order. Bits 15:8 of every word always read 0.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the addressed word at the clock edge. The stored value can be read back at once.
- R3: `link_speed` encodes 0 = 10, 1 = 100 and 2 = 1000 Mbit/s; code 3 matches no speed. Condition codes 1 to 7 are true only while `link_up` is high. Their meanings are: 1 = 10, 2 = 100, 3 = 10 or 100, 4 = 1000, 5 = 10 or 1000, 6 = 100 or 1000, 7 = any speed.
- R4: Condition code 8 follows power-down, 9 follows EEE mode, 0xA follows auto-negotiation, 0xB follows self-test and 0xC follows cable diagnostics. Code 0 is never true.
- R5: Condition codes 0xD to 0xF are never true, even when every status input is high.
- R6: In the shared rate word, bits 7:6 select the fast rate and bits 5:4 select the slow rate. Codes 00, 01, 10 and 11 give 2, 4, 8 and 16 Hz square waves. A blinking LED toggles every `CLK_HZ`/(2·rate) cycles.
- R7: In an LED's high word, bits 7:4 hold the constant-on condition and bits 3:0 hold the fast-blink condition. In its low word, bits 7:4 hold the slow-blink condition. The output priority is: fast blink, then slow blink, then constant on, then off.
- R8: Low-word bits 3:0 form an activity mask: bit 0 is transmit, bit 1 is receive, bit 2 is collision and bit 3 has no effect. A strobe whose mask bit is set starts a stretch of `CLK_HZ`/20 cycles, beginning at the next clock edge. A strobe whose mask bit is clear has no effect.
- R9: While a stretch is active the LED is off, whatever its other conditions.
- R10: Each LED decodes only its own two words, independently of the other LEDs.
- R11: LEDs set to the same blink rate and with a true condition show identical outputs on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Word address |
| cfg_wdata | input | 8 | Write data (the stored byte) |
| cfg_rdata | output | 16 | Read data of the addressed word, upper byte zero |
| link_up | input | 1 | Link established |
| link_speed | input | 2 | Speed code, 0 = 10, 1 = 100, 2 = 1000 |
| pwr_down | input | 1 | PHY powered down |
| eee_mode | input | 1 | Energy-efficient mode active |
| aneg_busy | input | 1 | Auto-negotiation running |
| selftest_busy | input | 1 | Analog self-test running |
| cablediag_busy | input | 1 | Cable diagnostics running |
| tx_act | input | 1 | Transmit activity strobe |
| rx_act | input | 1 | Receive activity strobe |
| col_det | input | 1 | Collision strobe |
| led | output | NUM_LED | LED drive, high = lit |

## Verification
On every cycle, the assertions check four things. A word reads back the value written to it one edge earlier. The blink phase moves only on a prescaler tick, and then by exactly one step. A masked strobe starts a stretch on the next edge. An LED is never lit while its stretch runs. Other behaviour can only be shown by the bench's scenarios: the decode of each condition code, the priority between competing conditions, the toggle counts that result from each rate code, the 50 ms stretch length, and the fact that separate LEDs stay in phase.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;

  typedef struct packed {
    logic       link;
    logic [1:0] speed;
    logic       pdown;
    logic       eee;
    logic       aneg;
    logic       abist;
    logic       cdiag;
  } phy_stat_t;

  // Reset contents of the configuration word at a given address.
  function automatic logic [7:0] reset_word(input int idx);
    case (idx)
      0:       return 8'hC5;
      1:       return 8'h67;
      2:       return 8'h70;
      3:       return 8'h03;
      4:       return 8'h20;
      6:       return 8'h40;
      8:       return 8'h40;
      9:       return 8'h20;
      default: return 8'h00;
    endcase
  endfunction

  // Whether a 4-bit condition code currently holds.
  function automatic logic cond_hit(input logic [3:0] code, input phy_stat_t s);
    logic s10, s100, s1g;
    s10  = s.link && (s.speed == 2'd0);
    s100 = s.link && (s.speed == 2'd1);
    s1g  = s.link && (s.speed == 2'd2);
    case (code)
      4'h1:    return s10;
      4'h2:    return s100;
      4'h3:    return s10 || s100;
      4'h4:    return s1g;
      4'h5:    return s10 || s1g;
      4'h6:    return s100 || s1g;
      4'h7:    return s.link;
      4'h8:    return s.pdown;
      4'h9:    return s.eee;
      4'hA:    return s.aneg;
      4'hB:    return s.abist;
      4'hC:    return s.cdiag;
      default: return 1'b0;
    endcase
  endfunction

  // Picks the square wave for a rate code: phase bit 0 runs at 16 Hz, bit 3 at 2 Hz.
  function automatic logic pick_wave(input logic [1:0] rate, input logic [3:0] phase);
    return phase[2'd3 - rate];
  endfunction

endpackage

// File: rtl/phy_led_regs.sv
module phy_led_regs #(
  parameter int NUM_LED = 4,
  parameter int ADDR_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [7:0]               wr_data,
  output logic [15:0]              rd_data,
  output logic [7:0]               rate_word,
  output logic [NUM_LED-1:0][7:0]  hi_word,
  output logic [NUM_LED-1:0][7:0]  lo_word
);
  import phy_led_pkg::*;

  localparam int NWORDS = 2 + 2 * NUM_LED;

  logic [7:0] words [NWORDS];
  logic       addr_ok;
  logic       wr_hit;

  assign addr_ok = int'(addr) < NWORDS;
  assign wr_hit  = wr_en && addr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) words[i] <= reset_word(i);
    end else if (wr_hit) begin
      words[addr] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr_ok) rd_data[7:0] = words[addr];
  end

  assign rate_word = words[0];

  for (genvar n = 0; n < NUM_LED; n++) begin : g_map
    assign hi_word[n] = words[2 + 2 * n];
    assign lo_word[n] = words[3 + 2 * n];
  end

  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_hit) && (addr == $past(addr))) |-> (rd_data[7:0] == $past(wr_data)));

endmodule

// File: rtl/phy_led_rate.sv
module phy_led_rate #(
  parameter int CLK_HZ = 100_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [3:0] phase
);
  localparam int TICK_CYC = (CLK_HZ / 32 < 2) ? 2 : CLK_HZ / 32;
  localparam int CW       = $clog2(TICK_CYC);

  logic [CW-1:0] div_cnt;
  logic          tick;

  assign tick = (div_cnt == CW'(TICK_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      phase   <= '0;
    end else if (tick) begin
      div_cnt <= '0;
      phase   <= phase + 4'd1;
    end else begin
      div_cnt <= div_cnt + CW'(1);
    end
  end

  // R6
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase));

  // R6
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (phase == $past(phase) + 4'd1));

endmodule

// File: rtl/phy_led_chan.sv
module phy_led_chan #(
  parameter int STRETCH_CYC = 5_000_000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [7:0]             hi,
  input  logic [7:0]             lo,
  input  phy_led_pkg::phy_stat_t stat,
  input  logic [2:0]             act,
  input  logic                   fast_wave,
  input  logic                   slow_wave,
  output logic                   led_o
);
  import phy_led_pkg::*;

  localparam int SW = $clog2(STRETCH_CYC + 1);

  logic [SW-1:0] hold_cnt;
  logic          act_hit;
  logic          stretch_on;
  logic          on_c, fast_c, slow_c;

  assign act_hit    = |(lo[3:0] & {1'b0, act});
  assign stretch_on = (hold_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hold_cnt <= '0;
    else if (act_hit)        hold_cnt <= SW'(STRETCH_CYC);
    else if (stretch_on)     hold_cnt <= hold_cnt - SW'(1);
  end

  assign on_c   = cond_hit(hi[7:4], stat);
  assign fast_c = cond_hit(hi[3:0], stat);
  assign slow_c = cond_hit(lo[7:4], stat);

  always_comb begin
    if (stretch_on)  led_o = 1'b0;
    else if (fast_c) led_o = fast_wave;
    else if (slow_c) led_o = slow_wave;
    else             led_o = on_c;
  end

  // R8
  act_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_hit |=> stretch_on);

  // R9
  stretch_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stretch_on |-> !led_o);

  // R8
  stretch_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(hold_cnt) <= STRETCH_CYC);

endmodule

// File: rtl/phy_led_ctrl.sv
module phy_led_ctrl #(
  parameter int CLK_HZ  = 100_000_000,
  parameter int NUM_LED = 4,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [7:0]         cfg_wdata,
  output logic [15:0]        cfg_rdata,
  input  logic               link_up,
  input  logic [1:0]         link_speed,
  input  logic               pwr_down,
  input  logic               eee_mode,
  input  logic               aneg_busy,
  input  logic               selftest_busy,
  input  logic               cablediag_busy,
  input  logic               tx_act,
  input  logic               rx_act,
  input  logic               col_det,
  output logic [NUM_LED-1:0] led
);
  import phy_led_pkg::*;

  localparam int STRETCH_CYC = (CLK_HZ / 20 < 1) ? 1 : CLK_HZ / 20;

  logic [7:0]              rate_word;
  logic [NUM_LED-1:0][7:0] hi_word;
  logic [NUM_LED-1:0][7:0] lo_word;
  logic [3:0]              phase;
  logic                    fast_wave, slow_wave;
  phy_stat_t               stat;

  assign stat = '{link: link_up, speed: link_speed, pdown: pwr_down, eee: eee_mode,
                  aneg: aneg_busy, abist: selftest_busy, cdiag: cablediag_busy};

  phy_led_regs #(.NUM_LED(NUM_LED), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we),
    .addr      (cfg_addr),
    .wr_data   (cfg_wdata),
    .rd_data   (cfg_rdata),
    .rate_word (rate_word),
    .hi_word   (hi_word),
    .lo_word   (lo_word)
  );

  phy_led_rate #(.CLK_HZ(CLK_HZ)) u_rate (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (phase)
  );

  assign fast_wave = pick_wave(rate_word[7:6], phase);
  assign slow_wave = pick_wave(rate_word[5:4], phase);

  for (genvar n = 0; n < NUM_LED; n++) begin : g_led
    phy_led_chan #(.STRETCH_CYC(STRETCH_CYC)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .hi        (hi_word[n]),
      .lo        (lo_word[n]),
      .stat      (stat),
      .act       ({col_det, rx_act, tx_act}),
      .fast_wave (fast_wave),
      .slow_wave (slow_wave),
      .led_o     (led[n])
    );
  end

endmodule

// File: tb/phy_led_ctrl_tb.sv
module phy_led_ctrl_tb;
  localparam int CLK_HZ = 3200;
  localparam int WIN    = 1600;   // half a second of clock cycles

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic       link_up = 1'b0;
  logic [1:0] link_speed = '0;
  logic       pwr_down = 1'b0, eee_mode = 1'b0, aneg_busy = 1'b0;
  logic       selftest_busy = 1'b0, cablediag_busy = 1'b0;
  logic       tx_act = 1'b0, rx_act = 1'b0, col_det = 1'b0;
  logic [3:0] led;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  phy_led_ctrl #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .link_up(link_up),
    .link_speed(link_speed), .pwr_down(pwr_down), .eee_mode(eee_mode),
    .aneg_busy(aneg_busy), .selftest_busy(selftest_busy),
    .cablediag_busy(cablediag_busy), .tx_act(tx_act), .rx_act(rx_act),
    .col_det(col_det), .led(led));

  // {hi, lo, link, speed, pdown eee aneg abist cdiag, kind}; kind 0 off, 1 on, 2 fast, 3 slow
  localparam logic [25:0] VEC [18] = '{
    {8'h70, 8'h00, 1'b1, 2'd0, 5'b00000, 2'd1},   // R3 any speed
    {8'h10, 8'h00, 1'b1, 2'd1, 5'b00000, 2'd0},   // R3 10 vs 100
    {8'h20, 8'h00, 1'b1, 2'd1, 5'b00000, 2'd1},   // R3
    {8'h50, 8'h00, 1'b1, 2'd2, 5'b00000, 2'd1},   // R3
    {8'h50, 8'h00, 1'b1, 2'd1, 5'b00000, 2'd0},   // R3
    {8'h60, 8'h00, 1'b1, 2'd2, 5'b00000, 2'd1},   // R3
    {8'h30, 8'h00, 1'b1, 2'd2, 5'b00000, 2'd0},   // R3
    {8'h80, 8'h00, 1'b0, 2'd0, 5'b10000, 2'd1},   // R4
    {8'h90, 8'h00, 1'b0, 2'd0, 5'b01000, 2'd1},   // R4
    {8'hA0, 8'h00, 1'b0, 2'd0, 5'b00100, 2'd1},   // R4
    {8'hB0, 8'h00, 1'b0, 2'd0, 5'b00010, 2'd1},   // R4
    {8'hC0, 8'h00, 1'b0, 2'd0, 5'b00001, 2'd1},   // R4
    {8'hDE, 8'hF0, 1'b1, 2'd2, 5'b11111, 2'd0},   // R5
    {8'h04, 8'h00, 1'b1, 2'd2, 5'b00000, 2'd2},   // R7 fast
    {8'h00, 8'h40, 1'b1, 2'd2, 5'b00000, 2'd3},   // R7 slow
    {8'h74, 8'h70, 1'b1, 2'd2, 5'b00000, 2'd2},   // R7 fast wins
    {8'h70, 8'h70, 1'b1, 2'd0, 5'b00000, 2'd3},   // R7 slow over on
    {8'h77, 8'h70, 1'b0, 2'd2, 5'b00000, 2'd0}    // R3 link down
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic measure(input int idx, output int ones, output int tog);
    logic prev;
    ones = 0; tog = 0;
    @(negedge clk);
    prev = led[idx];
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (led[idx]) ones++;
      if (led[idx] != prev) tog++;
      prev = led[idx];
    end
  endtask

  task automatic set_stat(input logic lk, input logic [1:0] sp, input logic [4:0] st);
    link_up = lk; link_speed = sp;
    {pwr_down, eee_mode, aneg_busy, selftest_busy, cablediag_busy} = st;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [7:0]  exp_rst [10] = '{8'hC5, 8'h67, 8'h70, 8'h03, 8'h20, 8'h00, 8'h40, 8'h00, 8'h40, 8'h20};
    int ones, tog, ones1, tog1, mism;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values and unmapped address
    for (int i = 0; i < 10; i++) begin
      rd(4'(i), d);
      chk(d == {8'h00, exp_rst[i]}, "R1 reset word", d, exp_rst[i]);
    end
    rd(4'd12, d);
    chk(d == 16'h0, "R1 unmapped read", d, 0);
    chk(led == 4'b0000, "R1 reset leds dark", led, 0);

    // R2 write then read back, unmapped write ignored
    wr(4'd4, 8'hCD);
    rd(4'd4, d);
    chk(d == 16'h00CD, "R2 readback", d, 16'h00CD);
    wr(4'd13, 8'hFF);
    rd(4'd13, d);
    chk(d == 16'h0, "R1 unmapped write", d, 0);
    wr(4'd4, 8'h00);

    // table of condition / priority vectors on LED0
    for (int v = 0; v < 18; v++) begin
      logic [25:0] e;
      int exp_t;
      e = VEC[v];
      wr(4'd2, e[25:18]);
      wr(4'd3, e[17:10]);
      set_stat(e[9], e[8:7], e[6:2]);
      measure(0, ones, tog);
      case (e[1:0])
        2'd0: chk(ones == 0, "R3/R4/R5/R7 off", ones, 0);
        2'd1: chk(ones == WIN, "R3/R4/R7 on", ones, WIN);
        default: begin
          exp_t = (e[1:0] == 2'd2) ? 16 : 2;
          chk(tog == exp_t, "R6/R7 blink toggles", tog, exp_t);
        end
      endcase
    end

    // R6 rate codes
    set_stat(1'b1, 2'd2, 5'b0);
    wr(4'd2, 8'h04); wr(4'd3, 8'h00);
    wr(4'd0, 8'h05);
    measure(0, ones, tog);
    chk(tog == 2, "R6 fast code 00", tog, 2);
    wr(4'd0, 8'h85);
    measure(0, ones, tog);
    chk(tog == 8, "R6 fast code 10", tog, 8);
    chk(ones == WIN / 2, "R6 duty", ones, WIN / 2);
    wr(4'd0, 8'hD5);
    wr(4'd2, 8'h00); wr(4'd3, 8'h40);
    measure(0, ones, tog);
    chk(tog == 4, "R6 slow code 01", tog, 4);
    wr(4'd0, 8'hC5);

    // R11 in phase: LED0 and LED1 both fast
    wr(4'd2, 8'h04); wr(4'd3, 8'h00);
    wr(4'd4, 8'h04); wr(4'd5, 8'h00);
    mism = 0; tog = 0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (led[0] != led[1]) mism++;
    end
    chk(mism == 0, "R11 same phase", mism, 0);

    // R10 independence: LED2 on for power-down, LED0 none, LED3 reset config
    wr(4'd2, 8'h00); wr(4'd3, 8'h00);
    wr(4'd6, 8'h80);
    set_stat(1'b1, 2'd2, 5'b10000);
    @(negedge clk);
    chk(led[2] == 1'b1 && led[0] == 1'b0, "R10 LED2 on, LED0 off", {led[2], led[0]}, 2'b10);
    chk(led[3] == 1'b1, "R10 LED3 reset config on at 1000", led[3], 1);
    set_stat(1'b1, 2'd1, 5'b0);
    measure(3, ones1, tog1);
    chk(tog1 == 2, "R10 LED3 slow at 100", tog1, 2);

    // R8 / R9 pulse stretch on LED0: link on, mask tx
    wr(4'd2, 8'h70); wr(4'd3, 8'h01);
    @(negedge clk);
    chk(led[0] == 1'b1, "R9 pre-pulse on", led[0], 1);
    tx_act = 1'b1;
    @(negedge clk);
    tx_act = 1'b0;
    chk(led[0] == 1'b0, "R9 stretch dark", led[0], 0);
    repeat (150) @(negedge clk);
    chk(led[0] == 1'b0, "R8 stretch still dark", led[0], 0);
    repeat (20) @(negedge clk);
    chk(led[0] == 1'b1, "R8 stretch ended", led[0], 1);
    // unmasked receive strobe ignored
    rx_act = 1'b1;
    @(negedge clk);
    rx_act = 1'b0;
    chk(led[0] == 1'b1, "R8 unmasked rx ignored", led[0], 1);
    repeat (10) @(negedge clk);
    chk(led[0] == 1'b1, "R8 unmasked rx ignored later", led[0], 1);
    // collision mask bit 2, with fast blink also true
    wr(4'd2, 8'h74); wr(4'd3, 8'h04);
    set_stat(1'b1, 2'd2, 5'b0);
    col_det = 1'b1;
    @(negedge clk);
    col_det = 1'b0;
    ones = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (led[0]) ones++;
    end
    chk(ones == 0, "R9 collision stretch over fast blink", ones, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule